// File: doc/BRIEF.md
# BCD Calendar Clock with Exact-Match Alarm

This block is a real-time clock peripheral with a byte-wide register port. It holds the current date and time as packed BCD (seconds, minutes, hours in 24-hour form, day of month, month, and a two-digit year that software treats as an offset from 2000). The time advances by one second each time a prescaler, clocked by a slow tick enable (nominally 32768 Hz), wraps around. The counting chain handles month lengths and leap years.

Software sets a six-field alarm. The alarm fires only when every field of the newly counted time equals the alarm exactly. A sticky alarm flag and a sticky power-up flag are cleared by writing ones. A busy indication covers the update window around each second rollover, so software knows when it may safely access the time. Two level interrupt outputs, each gated by an enable bit, report the per-second update and the alarm.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00:00:00 on day 01, month 01, year 00. Control reads 0x00, the interrupt-enable register reads 0x00 and status reads 0x80 (only the power-up bit 7 set). Both interrupt outputs are low.
- R2: The time fields sit at byte offsets 0x00 (seconds), 0x04 (minutes), 0x08 (hours), 0x0C (day), 0x10 (month) and 0x14 (year). The alarm fields are at the same order from 0x20 to 0x34. Control is at 0x40, status at 0x44 and interrupt enable at 0x48. A write takes effect on the next clock edge and reads back. Unmapped offsets read 0x00.
- R3: Control bit 0 enables counting, and status bit 1 (RUN) mirrors it. With bit 0 clear, no number of ticks changes the time. The other control bits are stored and read back with no effect; with bit 3 set, hours still roll 23 to 00.
- R4: While running, the seconds advance once per 2^DIV_W ticks. A host write to any time field restarts the prescaler phase, so the next advance comes exactly 2^DIV_W ticks after that write.
- R5: Seconds and minutes count 00 to 59 in BCD (for example 09 goes to 10) and carry into the next field on wrapping. Hours count 00 to 23 and carry into the day.
- R6: Day 30 is the last day of months 04, 06, 09 and 11, and day 31 is the last day of the other months except 02. In month 02 the last day is 29 when the year in binary is divisible by 4 (year 00 included) and 28 otherwise. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: Status bit 0 (BUSY) goes high on the tick that brings the prescaler to its last count. It stays high through the tick that updates the time, and goes low on the following tick. It is low while counting is disabled.
- R8: Status bits 2, 3, 4 and 5 report, for the most recent update, whether the seconds, minutes, hours and day fields changed.
- R9: Status bit 6 (ALARM) is set when an update produces a time equal to all six alarm fields. When any one field differs, it is not set.
- R10: Writing 1 to status bit 6 or bit 7 clears that flag. Writing 0 leaves it unchanged.
- R11: Interrupt-enable bit 3 (alarm) and bit 2 (timer) read back, and its other bits read 0. The alarm output is high exactly while the ALARM flag and bit 3 are both set.
- R12: With interrupt-enable bit 2 set, the timer output is high from the update until the next tick. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable at the slow tick rate |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 selects a write, 0 a read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_timer_o | output | 1 | Per-second timer interrupt level |
| irq_alarm_o | output | 1 | Alarm interrupt level |

## Verification
The bench drives each carry path: BCD tens carries inside a field, minute, hour and day rollover, every month-length class, and February in leap and common years including year 00. A wrong length table or leap rule would land on a wrong day, or on 02-29 in a common year. It counts ticks against the busy window and the phase restart, so an off-by-one prescaler or a write that fails to restart the phase shows up as an early or late second. It also checks that an alarm one field away does not fire, that writing zero to the sticky flags does not clear them, and that the interrupt gating holds. A design that masked a field, cleared on any write, or ignored an enable bit would fail these checks.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NUM_FIELDS = 6;

    localparam logic [2:0] PAGE_TIME  = 3'b000;
    localparam logic [2:0] PAGE_ALARM = 3'b001;
    localparam logic [7:0] OFS_CTRL   = 8'h40;
    localparam logic [7:0] OFS_STAT   = 8'h44;
    localparam logic [7:0] OFS_IEN    = 8'h48;

    typedef logic [7:0] bcd8_t;

    // Lowest byte is seconds so that byte lane index equals addr[4:2].
    typedef struct packed {
        bcd8_t year;
        bcd8_t mon;
        bcd8_t day;
        bcd8_t hour;
        bcd8_t min;
        bcd8_t sec;
    } cal_time_t;

    typedef struct packed {
        cal_time_t   tm;
        cal_time_t   alm;
        logic [7:0]  ctrl;
        logic        pwr;
        logic        alarm;
        logic [3:0]  ev;
        logic        en_alarm;
        logic        en_timer;
    } rtc_regs_t;

    localparam cal_time_t TIME_RESET = '{year: 8'h00, mon: 8'h01, day: 8'h01,
                                         hour: 8'h00, min: 8'h00, sec: 8'h00};

    localparam rtc_regs_t REGS_RESET = '{tm: TIME_RESET, alm: '0, ctrl: 8'h00,
                                         pwr: 1'b1, alarm: 1'b0, ev: 4'h0,
                                         en_alarm: 1'b0, en_timer: 1'b0};

    // Step a BCD value by one, wrapping from last back to first.
    function automatic bcd8_t bcd_next(bcd8_t v, bcd8_t last, bcd8_t first);
        if (v == last) begin
            return first;
        end
        if (v[3:0] >= 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // 10*t + u is congruent to 2*t + u modulo 4.
    function automatic logic is_leap(bcd8_t y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic bcd8_t month_last(bcd8_t m, bcd8_t y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic restart_i,
    output logic stb_o,
    output logic busy_o,
    output logic post_o
);
    localparam logic [DIV_W-1:0] CNT_LAST = {DIV_W{1'b1}};
    localparam logic [DIV_W-1:0] CNT_ONE  = {{(DIV_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             post;
    } pre_state_t;

    pre_state_t s_q, s_d;
    logic       step;
    logic       at_last;

    always_comb begin
        s_d     = s_q;
        step    = tick_i & run_i;
        at_last = (s_q.cnt == CNT_LAST);
        stb_o   = step & at_last & ~restart_i;
        if (restart_i) begin
            s_d.cnt  = '0;
            s_d.post = 1'b0;
        end else if (step) begin
            s_d.cnt  = s_q.cnt + CNT_ONE;
            s_d.post = at_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = run_i & (at_last | s_q.post);
    assign post_o = run_i & s_q.post;

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_cal_pkg::*;
(
    input  cal_time_t  cur_i,
    output cal_time_t  nxt_o,
    output logic [3:0] roll_o
);
    logic  c_min, c_hour, c_day, c_mon, c_year;
    bcd8_t last_day;

    always_comb begin
        nxt_o    = cur_i;
        last_day = month_last(cur_i.mon, cur_i.year);
        c_min    = (cur_i.sec == 8'h59);
        c_hour   = c_min  & (cur_i.min  == 8'h59);
        c_day    = c_hour & (cur_i.hour == 8'h23);
        c_mon    = c_day  & (cur_i.day  == last_day);
        c_year   = c_mon  & (cur_i.mon  == 8'h12);

        nxt_o.sec = bcd_next(cur_i.sec, 8'h59, 8'h00);
        if (c_min) begin
            nxt_o.min = bcd_next(cur_i.min, 8'h59, 8'h00);
        end
        if (c_hour) begin
            nxt_o.hour = bcd_next(cur_i.hour, 8'h23, 8'h00);
        end
        if (c_day) begin
            nxt_o.day = bcd_next(cur_i.day, last_day, 8'h01);
        end
        if (c_mon) begin
            nxt_o.mon = bcd_next(cur_i.mon, 8'h12, 8'h01);
        end
        if (c_year) begin
            nxt_o.year = bcd_next(cur_i.year, 8'h99, 8'h00);
        end
        // {day, hour, minute, second} changed flags
        roll_o = {c_day, c_hour, c_min, 1'b1};
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_cal_pkg::*;
(
    input  cal_time_t now_i,
    input  cal_time_t alm_i,
    output logic      hit_o
);
    logic [8*NUM_FIELDS-1:0] now_flat, alm_flat;
    logic [NUM_FIELDS-1:0]   lane_eq;

    assign now_flat = now_i;
    assign alm_flat = alm_i;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_lane
        assign lane_eq[g] = (now_flat[8*g +: 8] == alm_flat[8*g +: 8]);
    end

    assign hit_o = &lane_eq;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       sel_i,
    input  logic       wr_i,
    input  logic [7:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       irq_timer_o,
    output logic       irq_alarm_o
);
    localparam int FLAT_W = 8 * NUM_FIELDS;

    rtc_regs_t   r_q, r_d;
    cal_time_t   nxt_tm;
    logic [3:0]  roll;
    logic        hit;
    logic        stb, busy, post;
    logic        wr, run, tm_wr, alm_wr, stat_wr;
    logic        lane_ok, time_hit, alm_hit;
    logic [2:0]  idx;
    logic [FLAT_W-1:0] tm_flat, alm_flat;
    logic [7:0]  status;

    assign idx      = addr_i[4:2];
    assign lane_ok  = (addr_i[1:0] == 2'b00) && (int'(idx) < NUM_FIELDS);
    assign time_hit = lane_ok && (addr_i[7:5] == PAGE_TIME);
    assign alm_hit  = lane_ok && (addr_i[7:5] == PAGE_ALARM);
    assign wr       = sel_i & wr_i;
    assign tm_wr    = wr & time_hit;
    assign alm_wr   = wr & alm_hit;
    assign stat_wr  = wr & (addr_i == OFS_STAT);
    assign run      = r_q.ctrl[0];
    assign tm_flat  = r_q.tm;
    assign alm_flat = r_q.alm;

    rtc_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .run_i     (run),
        .restart_i (tm_wr),
        .stb_o     (stb),
        .busy_o    (busy),
        .post_o    (post)
    );

    rtc_time_chain u_chain (
        .cur_i  (r_q.tm),
        .nxt_o  (nxt_tm),
        .roll_o (roll)
    );

    rtc_alarm_match u_match (
        .now_i (nxt_tm),
        .alm_i (r_q.alm),
        .hit_o (hit)
    );

    always_comb begin
        logic [FLAT_W-1:0] t_upd;
        logic [FLAT_W-1:0] a_upd;
        r_d   = r_q;
        t_upd = tm_flat;
        a_upd = alm_flat;

        if (stat_wr) begin
            if (wdata_i[6]) r_d.alarm = 1'b0;
            if (wdata_i[7]) r_d.pwr   = 1'b0;
        end
        if (stb) begin
            r_d.tm = nxt_tm;
            r_d.ev = roll;
            if (hit) r_d.alarm = 1'b1;
        end
        if (tm_wr) begin
            t_upd[8*idx +: 8] = wdata_i;
            r_d.tm = t_upd;
        end
        if (alm_wr) begin
            a_upd[8*idx +: 8] = wdata_i;
            r_d.alm = a_upd;
        end
        if (wr && addr_i == OFS_CTRL) begin
            r_d.ctrl = wdata_i;
        end
        if (wr && addr_i == OFS_IEN) begin
            r_d.en_alarm = wdata_i[3];
            r_d.en_timer = wdata_i[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign status = {r_q.pwr, r_q.alarm, r_q.ev, run, busy};

    always_comb begin
        rdata_o = 8'h00;
        if (time_hit) begin
            rdata_o = tm_flat[8*idx +: 8];
        end else if (alm_hit) begin
            rdata_o = alm_flat[8*idx +: 8];
        end else begin
            case (addr_i)
                OFS_CTRL: rdata_o = r_q.ctrl;
                OFS_STAT: rdata_o = status;
                OFS_IEN:  rdata_o = {4'h0, r_q.en_alarm, r_q.en_timer, 2'b00};
                default:  rdata_o = 8'h00;
            endcase
        end
    end

    assign irq_alarm_o = r_q.alarm & r_q.en_alarm;
    assign irq_timer_o = r_q.en_timer & post;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      busy,
    input logic      tm_wr,
    input logic      run,
    input logic      stat_wr,
    input logic [7:0] wdata,
    input logic      alarm_flag,
    input logic      pwr_flag,
    input logic      en_alarm,
    input logic      irq_timer,
    input logic      irq_alarm,
    input cal_time_t tm
);
    // R7: counting only changes the time inside the busy window
    p_time_moves_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tm) && !$past(tm_wr)) |-> $past(busy));

    // R3: a stopped clock keeps its time unless the host writes it
    p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !tm_wr) |=> $stable(tm));

    // R9: the alarm flag only rises at a counting update
    p_alarm_on_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(busy));

    // R10: the sticky flags fall only after a write of one to their bit
    p_alarm_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flag) |-> $past(stat_wr && wdata[6]));

    p_pwr_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_flag) |-> $past(stat_wr && wdata[7]));

    // R11: the alarm interrupt needs its enable
    p_alarm_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_alarm |-> en_alarm);

    // R12: the timer interrupt lies inside the busy window
    p_timer_in_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timer |-> busy);

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .tm_wr      (tm_wr),
    .run        (run),
    .stat_wr    (stat_wr),
    .wdata      (wdata_i),
    .alarm_flag (r_q.alarm),
    .pwr_flag   (r_q.pwr),
    .en_alarm   (r_q.en_alarm),
    .irq_timer  (irq_timer_o),
    .irq_alarm  (irq_alarm_o),
    .tm         (r_q.tm)
);

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
    localparam int DIV_W = 2;
    localparam int TICKS_PER_SEC = 1 << DIV_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       sel_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] addr_i = 8'h00;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       irq_timer_o, irq_alarm_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_calendar #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sel_i(sel_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .irq_timer_o(irq_timer_o), .irq_alarm_o(irq_alarm_o)
    );

    // start time, expected time one second later, expected {day,hour,min,sec} events
    typedef struct packed {
        logic [47:0] t0;
        logic [47:0] t1;
        logic [3:0]  ev;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{48'h24_01_15_10_20_30, 48'h24_01_15_10_20_31, 4'b0001},
        '{48'h24_03_10_00_00_59, 48'h24_03_10_00_01_00, 4'b0011},
        '{48'h24_03_10_12_59_59, 48'h24_03_10_13_00_00, 4'b0111},
        '{48'h24_03_10_19_59_59, 48'h24_03_10_20_00_00, 4'b0111},
        '{48'h24_01_31_23_59_59, 48'h24_02_01_00_00_00, 4'b1111},
        '{48'h24_04_30_23_59_59, 48'h24_05_01_00_00_00, 4'b1111},
        '{48'h23_02_28_23_59_59, 48'h23_03_01_00_00_00, 4'b1111},
        '{48'h24_02_28_23_59_59, 48'h24_02_29_00_00_00, 4'b1111},
        '{48'h24_02_29_23_59_59, 48'h24_03_01_00_00_00, 4'b1111},
        '{48'h00_02_28_23_59_59, 48'h00_02_29_00_00_00, 4'b1111},
        '{48'h99_12_31_23_59_59, 48'h00_01_01_00_00_00, 4'b1111},
        '{48'h24_09_29_23_59_59, 48'h24_09_30_00_00_00, 4'b1111},
        '{48'h24_11_30_23_59_59, 48'h24_12_01_00_00_00, 4'b1111},
        '{48'h24_07_31_23_59_59, 48'h24_08_01_00_00_00, 4'b1111},
        '{48'h24_08_09_23_59_59, 48'h24_08_10_00_00_00, 4'b1111},
        '{48'h24_12_31_23_59_59, 48'h25_01_01_00_00_00, 4'b1111}
    };

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        sel_i = 1'b0; wr_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr_i = a; sel_i = 1'b1; wr_i = 1'b0;
        #1 d = rdata_o;
        sel_i = 1'b0;
    endtask

    task automatic tick1();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick1();
    endtask

    task automatic set_fields(input logic [7:0] base, input logic [47:0] t);
        for (int f = 0; f < 6; f++) wr(base + 8'(4 * f), t[8*f +: 8]);
    endtask

    task automatic get_time(output logic [47:0] t);
        logic [7:0] b;
        for (int f = 0; f < 6; f++) begin
            rd(8'(4 * f), b);
            t[8*f +: 8] = b;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [47:0] t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        get_time(t);
        chk("R1 time", t, 48'h00_01_01_00_00_00);
        rd(8'h40, b); chk("R1 ctrl", b, 8'h00);
        rd(8'h44, b); chk("R1 status", b, 8'h80);
        rd(8'h48, b); chk("R1 ien", b, 8'h00);
        chk("R1 irqs", {irq_timer_o, irq_alarm_o}, 2'b00);

        // R2 unmapped offset
        rd(8'h3C, b); chk("R2 unmapped", b, 8'h00);

        // R10 power-up flag: zero keeps it, one clears it
        wr(8'h44, 8'h00); rd(8'h44, b); chk("R10 pwr keep", b, 8'h80);
        wr(8'h44, 8'h80); rd(8'h44, b); chk("R10 pwr clear", b, 8'h00);

        // R11 enable register readback
        wr(8'h48, 8'hFF); rd(8'h48, b); chk("R11 ien mask", b, 8'h0C);
        wr(8'h48, 8'h00); rd(8'h48, b); chk("R11 ien off", b, 8'h00);

        // R3 run bit mirrored in status
        wr(8'h40, 8'h01); rd(8'h44, b); chk("R3 run status", b, 8'h02);

        // Vector table: R5 R6 R8 and R4 (one second per 2^DIV_W ticks)
        for (int i = 0; i < NV; i++) begin
            set_fields(8'h00, VECS[i].t0);
            ticks(TICKS_PER_SEC);
            get_time(t);
            chk("R5/R6 next time", t, VECS[i].t1);
            rd(8'h44, b);
            chk("R8 events", b, {2'b00, VECS[i].ev, 2'b11});
        end

        // R7 busy window and R12 timer interrupt
        wr(8'h48, 8'h04);
        set_fields(8'h00, 48'h24_06_01_10_00_10);
        ticks(TICKS_PER_SEC - 2);
        rd(8'h44, b); chk("R7 busy low early", b[0], 1'b0);
        tick1();
        rd(8'h44, b); chk("R7 busy before update", b[0], 1'b1);
        rd(8'h00, b); chk("R7 not yet advanced", b, 8'h10);
        chk("R12 timer low before", irq_timer_o, 1'b0);
        tick1();
        rd(8'h44, b); chk("R7 busy after update", b[0], 1'b1);
        rd(8'h00, b); chk("R7 advanced", b, 8'h11);
        chk("R12 timer high", irq_timer_o, 1'b1);
        tick1();
        rd(8'h44, b); chk("R7 busy cleared", b[0], 1'b0);
        chk("R12 timer cleared", irq_timer_o, 1'b0);
        wr(8'h48, 8'h00);
        set_fields(8'h00, 48'h24_06_01_10_00_20);
        ticks(TICKS_PER_SEC);
        chk("R12 timer gated off", irq_timer_o, 1'b0);

        // R4 a time write restarts the phase
        set_fields(8'h00, 48'h24_06_01_10_00_30);
        ticks(2);
        wr(8'h00, 8'h40);
        ticks(TICKS_PER_SEC - 1);
        rd(8'h00, b); chk("R4 restart holds", b, 8'h40);
        tick1();
        rd(8'h00, b); chk("R4 restart advance", b, 8'h41);

        // R3 stopped clock ignores ticks
        wr(8'h40, 8'h00);
        rd(8'h44, b); chk("R3 stop status", b[1:0], 2'b00);
        ticks(3 * TICKS_PER_SEC);
        rd(8'h00, b); chk("R3 stopped time", b, 8'h41);
        // R3 other control bits stored, no effect on 24-hour counting
        wr(8'h40, 8'h0F);
        rd(8'h40, b); chk("R3 ctrl readback", b, 8'h0F);
        set_fields(8'h00, 48'h24_06_01_23_59_59);
        ticks(TICKS_PER_SEC);
        get_time(t); chk("R3 hour wrap with bit3", t, 48'h24_06_02_00_00_00);
        wr(8'h40, 8'h01);

        // R9 exact alarm, R2 alarm readback, R11 gating, R10 clearing
        set_fields(8'h00, 48'h24_05_05_08_30_00);
        set_fields(8'h20, 48'h24_05_05_08_30_01);
        rd(8'h28, b); chk("R2 alarm hour readback", b, 8'h08);
        ticks(TICKS_PER_SEC);
        rd(8'h44, b); chk("R9 alarm set", b[6], 1'b1);
        chk("R11 alarm irq gated", irq_alarm_o, 1'b0);
        wr(8'h48, 8'h08);
        chk("R11 alarm irq high", irq_alarm_o, 1'b1);
        wr(8'h44, 8'h00);
        rd(8'h44, b); chk("R10 alarm keep", b[6], 1'b1);
        wr(8'h44, 8'h40);
        rd(8'h44, b); chk("R10 alarm clear", b[6], 1'b0);
        chk("R11 alarm irq low", irq_alarm_o, 1'b0);

        // R9 one field off: no alarm
        set_fields(8'h20, 48'h25_05_05_08_30_02);
        ticks(TICKS_PER_SEC);
        rd(8'h00, b); chk("R9 time reached", b, 8'h02);
        rd(8'h44, b); chk("R9 year mismatch", b[6], 1'b0);
        chk("R9 irq stays low", irq_alarm_o, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule